// File: doc/BRIEF.md
# Calibration Trim-DAC Serial Loader

This block takes host writes of 8-bit calibration values aimed at one of 21 trim channels and delivers each one to the right serial trim converter. The channels are spread over three chips with eight inputs each. One chip holds channels 0-7, the next holds 8-15, and the third holds 16-20. All three chips share a data line and a clock line. For each write, the block shifts out an 11-bit word. The upper three bits of that word give the input within the chip, and the lower eight bits carry the value. The block then drives a 2-bit load code for one half clock period, which tells the addressed chip to latch the word.

The converters cannot be read back, so the block keeps a shadow copy of the last value written to each channel. A combinational read port returns that copy. Writes use a valid/ready handshake. While a transfer is in progress, ready is low and busy is high. A divider input sets how long each half of the serial clock lasts, counted in system clocks. The block samples the divider when it accepts a write, so changing it later does not affect a transfer already under way.

Top module: `trim_dac_loader`

## Requirements
- R1: Each accepted write shifts exactly 11 bits, most significant bit first. Word bits 10:8 hold the low three bits of the channel number, and bits 7:0 hold the value.
- R2: For each bit, the data line changes only while the clock is low. The clock then rises with the data held unchanged. Each half period lasts H system clocks, where H is the divider value sampled at acceptance, and a divider value of 0 is treated as 1.
- R3: After the 11th bit, the load code equals (channel >> 3) + 1 for H cycles. The code is 1 for the chip holding 0-7, 2 for 8-15 and 3 for 16-20. It then returns to 0, which means idle.
- R4: Busy is high from the cycle after acceptance for exactly 23*H cycles. Ready is always the inverse of busy.
- R5: An accepted in-range write stores its 8-bit value in that channel's shadow register. The read port returns the shadow of the addressed channel in the same cycle, and returns 0 for a channel above 20.
- R6: A write to a channel from 21 to 31 completes its handshake, raises the error output for exactly one cycle (the next cycle), and starts no serial activity. It leaves busy low and changes no shadow register.
- R7: During and after reset, the data, clock and load-code outputs are 0, every shadow register reads 0x00, ready is high and busy is low.
- R8: The load code is never nonzero while the serial clock is high. Whenever busy is low, the data, clock and load-code outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | 8 | Half serial-clock period in system clocks (0 treated as 1) |
| wr_valid_i | input | 1 | Write request |
| wr_ready_o | output | 1 | Write can be accepted |
| wr_chan_i | input | 5 | Target trim channel |
| wr_data_i | input | 8 | Calibration value |
| wr_err_o | output | 1 | One-cycle pulse for an out-of-range channel |
| rd_chan_i | input | 5 | Readback channel |
| rd_data_o | output | 8 | Shadow value of the readback channel |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Serial clock |
| ld_code_o | output | 2 | Chip load select (0 means idle) |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions check a handshake that is accepted only when the valid input meets a high ready. They assume nothing about the channel and data inputs outside the accepting cycle, and nothing about the divider while a transfer runs, because the block latches the divider at acceptance. The stimulus raises valid only when the block is idle and holds it for a single clock. It changes the divider only between transfers. It sweeps every channel code from 0 to 31 under divider values 0, 1, 2 and 3, with boundary values 0x00 and 0xFF at the chip edges.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOAD = 2'd3
  } ser_state_e;
endpackage

// File: rtl/trim_shadow_file.sv
module trim_shadow_file #(
  parameter int NUM_CH = 21,
  parameter int DATA_W = 8,
  parameter int CH_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CH_W-1:0]   wchan_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CH_W-1:0]   rchan_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && (wchan_i == CH_W'(g)))       mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rchan_i == CH_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/trim_serializer.sv
module trim_serializer
  import trim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int LD_W   = 2,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LD_W-1:0]   code_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic [LD_W-1:0]   ld_code_o,
  output logic              busy_o
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int IDX_W  = $clog2(WORD_W);

  ser_state_e         state_q;
  logic [WORD_W-1:0]  word_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DIV_W-1:0]   half_q, cnt_q;
  logic [LD_W-1:0]    code_q;
  logic               half_done;

  assign half_done = (cnt_q == half_q - DIV_W'(1));
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      word_q    <= '0;
      idx_q     <= '0;
      half_q    <= DIV_W'(1);
      cnt_q     <= '0;
      code_q    <= '0;
      sdata_o   <= 1'b0;
      sclk_o    <= 1'b0;
      ld_code_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          word_q  <= {addr_i, data_i};
          code_q  <= code_i;
          half_q  <= (div_i == '0) ? DIV_W'(1) : div_i;
          idx_q   <= IDX_W'(WORD_W - 1);
          cnt_q   <= '0;
          sdata_o <= addr_i[ADDR_W-1];  // MSB of the word
          sclk_o  <= 1'b0;
          state_q <= ST_LOW;
        end
        ST_LOW: begin
          cnt_q <= half_done ? '0 : cnt_q + DIV_W'(1);
          if (half_done) begin
            sclk_o  <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          cnt_q <= half_done ? '0 : cnt_q + DIV_W'(1);
          if (half_done) begin
            sclk_o <= 1'b0;
            if (idx_q == '0) begin
              ld_code_o <= code_q;
              state_q   <= ST_LOAD;
            end else begin
              idx_q   <= idx_q - IDX_W'(1);
              sdata_o <= word_q[idx_q - IDX_W'(1)];
              state_q <= ST_LOW;
            end
          end
        end
        ST_LOAD: begin
          cnt_q <= half_done ? '0 : cnt_q + DIV_W'(1);
          if (half_done) begin
            ld_code_o <= '0;
            sdata_o   <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_dac_loader.sv
module trim_dac_loader #(
  parameter int NUM_CH      = 21,
  parameter int CH_PER_CHIP = 8,
  parameter int DATA_W      = 8,
  parameter int LD_W        = 2,
  parameter int DIV_W       = 8,
  parameter int CH_W        = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_err_o,
  input  logic [CH_W-1:0]   rd_chan_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic [LD_W-1:0]   ld_code_o,
  output logic              busy_o
);
  localparam int ADDR_W = $clog2(CH_PER_CHIP);

  logic accept, chan_ok, start;
  logic [LD_W-1:0] code;

  assign chan_ok    = (wr_chan_i < CH_W'(NUM_CH));
  assign wr_ready_o = ~busy_o;
  assign accept     = wr_valid_i & wr_ready_o;
  assign start      = accept & chan_ok;
  assign code       = LD_W'(wr_chan_i >> ADDR_W) + LD_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_err_o <= 1'b0;
    else         wr_err_o <= accept & ~chan_ok;
  end

  trim_shadow_file #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)
  ) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (start),
    .wchan_i (wr_chan_i),
    .wdata_i (wr_data_i),
    .rchan_i (rd_chan_i),
    .rdata_o (rd_data_o)
  );

  trim_serializer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LD_W(LD_W), .DIV_W(DIV_W)
  ) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .addr_i    (wr_chan_i[ADDR_W-1:0]),
    .data_i    (wr_data_i),
    .code_i    (code),
    .div_i     (half_div_i),
    .sdata_o   (sdata_o),
    .sclk_o    (sclk_o),
    .ld_code_o (ld_code_o),
    .busy_o    (busy_o)
  );
endmodule

// File: rtl/trim_dac_loader_chk.sv
module trim_dac_loader_chk #(
  parameter int NUM_CH = 21,
  parameter int LD_W   = 2,
  parameter int CH_W   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_valid_i,
  input logic            wr_ready_o,
  input logic [CH_W-1:0] wr_chan_i,
  input logic            wr_err_o,
  input logic            sdata_o,
  input logic            sclk_o,
  input logic [LD_W-1:0] ld_code_o,
  input logic            busy_o
);
  a_r2_data_stable_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  a_r8_no_load_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_code_o != '0) |-> !sclk_o);
  a_r8_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sdata_o && !sclk_o && ld_code_o == '0));
  a_r4_ready_inv_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o == !busy_o);
  a_r4_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && wr_chan_i < CH_W'(NUM_CH)) |=> busy_o);
  a_r6_err_no_activity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && wr_chan_i >= CH_W'(NUM_CH)) |=> (wr_err_o && !busy_o));
  a_r3_load_before_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ld_code_o) != '0);
endmodule

bind trim_dac_loader trim_dac_loader_chk #(
  .NUM_CH(NUM_CH), .LD_W(LD_W), .CH_W(CH_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .wr_chan_i  (wr_chan_i),
  .wr_err_o   (wr_err_o),
  .sdata_o    (sdata_o),
  .sclk_o     (sclk_o),
  .ld_code_o  (ld_code_o),
  .busy_o     (busy_o)
);

// File: tb/trim_dac_loader_test.sv
module trim_dac_loader_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [7:0] half_div = 8'd1;
  logic       wr_valid = 0;
  logic [4:0] wr_chan = '0, rd_chan = '0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, wr_err, sdata, sclk, busy;
  logic [7:0] rd_data;
  logic [1:0] ld_code;

  int checks = 0, fails = 0;
  logic [7:0] model [32];

  // serial monitor
  logic [10:0] cap;
  int nbits, ld_cycles, busy_cycles, err_cycles;
  logic [1:0] ld_seen;
  logic prev_sclk = 0;
  bit   data_bad;
  logic prev_sdata = 0;

  trim_dac_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .half_div_i(half_div),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_chan_i(wr_chan),
    .wr_data_i(wr_data), .wr_err_o(wr_err), .rd_chan_i(rd_chan),
    .rd_data_o(rd_data), .sdata_o(sdata), .sclk_o(sclk),
    .ld_code_o(ld_code), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !prev_sclk) begin cap = {cap[9:0], sdata}; nbits++; end
      if (sclk && prev_sclk && sdata != prev_sdata) data_bad = 1;
      if (ld_code != 0) begin ld_seen = ld_code; ld_cycles++; end
      if (busy) busy_cycles++;
      if (wr_err) err_cycles++;
      prev_sclk = sclk;
      prev_sdata = sdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write(input int ch, input int val);
    cap = '0; nbits = 0; ld_cycles = 0; busy_cycles = 0; err_cycles = 0;
    ld_seen = '0; data_bad = 0;
    @(negedge clk);
    wr_valid = 1; wr_chan = 5'(ch); wr_data = 8'(val);
    @(negedge clk);
    wr_valid = 0; wr_chan = 5'h1f; wr_data = 8'h5a;
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all_reads(input string tag);
    for (int c = 0; c < 32; c++) begin
      rd_chan = 5'(c);
      #1;
      check(rd_data == model[c], tag, rd_data, model[c]);
    end
  endtask

  initial begin
    for (int c = 0; c < 32; c++) model[c] = 8'h00;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(!sdata && !sclk && ld_code == 0, "R7 lines idle in reset", {sdata, sclk, ld_code}, 0);
    check(wr_ready && !busy, "R7 ready in reset", {wr_ready, busy}, 2);
    rst_n = 1;
    @(negedge clk);
    check_all_reads("R7 shadow reset");

    for (int d = 0; d < 4; d++) begin
      int h;
      half_div = 8'(d);
      h = (d == 0) ? 1 : d;
      for (int ch = 0; ch < 32; ch++) begin
        int val, before5;
        val = (ch * 37 + d * 91 + 13) & 8'hff;
        if (ch == 0 || ch == 7 || ch == 8) val = (d[0]) ? 8'hff : 8'h00;
        if (ch == 20) val = (d[0]) ? 8'h00 : 8'hff;
        before5 = model[ch & 7];
        write(ch, val);
        if (ch < 21) begin
          model[ch] = 8'(val);
          check(nbits == 11, "R1 bit count", nbits, 11);
          check(cap == {3'(ch & 7), 8'(val)}, "R1 word", cap, {3'(ch & 7), 8'(val)});
          check(!data_bad, "R2 data stable while clock high", data_bad, 0);
          check(ld_seen == 2'((ch >> 3) + 1), "R3 load code", ld_seen, (ch >> 3) + 1);
          check(ld_cycles == h, "R3 load duration", ld_cycles, h);
          check(busy_cycles == 23 * h, "R2 R4 busy length", busy_cycles, 23 * h);
          check(err_cycles == 0, "R6 no error in range", err_cycles, 0);
          rd_chan = 5'(ch); #1;
          check(rd_data == 8'(val), "R5 readback", rd_data, val);
        end else begin
          check(err_cycles == 1, "R6 error pulse", err_cycles, 1);
          check(nbits == 0 && ld_cycles == 0 && busy_cycles == 0,
                "R6 no serial activity", nbits + ld_cycles + busy_cycles, 0);
          rd_chan = 5'(ch & 7); #1;
          check(rd_data == 8'(before5), "R6 shadow untouched", rd_data, before5);
          rd_chan = 5'(ch); #1;
          check(rd_data == 8'h00, "R5 out-of-range read", rd_data, 0);
        end
        check(!sdata && !sclk && ld_code == 0 && wr_ready, "R8 idle after transfer",
              {sdata, sclk, ld_code, wr_ready}, 1);
      end
      check_all_reads("R5 shadow file");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule